// File: doc/BRIEF.md
# Root Port PME and Error Escalation Control

This block is the control slice of one PCI Express root port that governs two things: whether correctable errors are escalated to the core error logic, and whether power-management events are signalled to the platform as ACPI general-purpose-event messages. Software programs it through a simple register write/read port. Two bits matter: an override that forces correctable errors through whatever the root-control enable says, and an enable for the PME event messages.

The block remembers whether the last message that left it was an assert or a deassert. When software turns the message enable off while an assert is still outstanding, the block issues one cleanup deassert of its own, so the platform is never left with a stuck event. Messages leave through a valid/ready handshake. The downstream transport of the messages is outside this block.

Top module: `rp_pme_err_ctl`

## Requirements
- R1: After reset both control bits are 0, the read data is all zeros, no message is offered and no escalation pulse is driven.
- R2: A write loads write-data bit 1 into the override bit and write-data bit 0 into the message enable. Reads return the override in bit 1, the enable in bit 0 and zero in every other bit.
- R3: With the override bit at 1, every correctable-error pulse produces an escalation pulse, whatever the root-control enable input says.
- R4: With the override bit at 0, a correctable-error pulse produces an escalation pulse only when the root-control enable input is 1. The escalation pulse is one cycle wide and appears in the cycle after the error pulse.
- R5: A PME request or clear produces a message only while the enable bit is 1 and ACPI mode is active.
- R6: Message type 0 is an assert and type 1 is a deassert. A request produces an assert only when the last accepted message was not an assert. A clear produces a deassert only when the last accepted message was an assert.
- R7: An offered message holds valid with an unchanged type until ready is seen. The last-sent state updates on acceptance, and request or clear pulses that arrive while a message is waiting are ignored.
- R8: Clearing the enable bit from 1 to 0 when the last message was an assert produces exactly one deassert. This happens even when ACPI mode is inactive.
- R9: Clearing the enable bit when the last message was a deassert, or when no message has been sent, produces no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| rootctrl_ce_en | input | 1 | Root-control enable for correctable error reporting |
| acpi_mode | input | 1 | ACPI handling of PME is active |
| corr_err | input | 1 | One-cycle pulse: a correctable error reached the primary side |
| pme_req | input | 1 | One-cycle pulse: request an assert message |
| pme_clr | input | 1 | One-cycle pulse: request a deassert message |
| esc_pulse | output | 1 | One-cycle escalation to the core error logic |
| msg_valid | output | 1 | A message is offered |
| msg_type | output | 1 | 0 = assert, 1 = deassert |
| msg_ready | input | 1 | Downstream accepts the offered message |

## Verification
A corrupted last-sent flag is visible at the message port within a few cycles. It shows up as a second assert with no deassert between them, a clear that sends nothing, or a disable that fails to send its cleanup deassert or sends one too many. The scoreboard expects an exact sequence of message types, so a missing or extra message is reported as soon as it reaches the handshake or when the run ends. A wrong gate on escalation shows on the very next cycle as a missing or extra pulse.

// File: rtl/rp_ctl_pkg.sv
package rp_ctl_pkg;

  typedef enum logic {
    MSG_ASSERT   = 1'b0,
    MSG_DEASSERT = 1'b1
  } pme_msg_e;

  // Escalation gate: override bypasses the root-control enable.
  function automatic logic esc_allowed(input logic ovr, input logic ce_en);
    return ovr | ce_en;
  endfunction

endpackage

// File: rtl/rp_ctl_regfile.sv
module rp_ctl_regfile #(
  parameter int DATA_W  = 32,
  parameter int OVR_BIT = 1,
  parameter int EN_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              ovr_q,
  output logic              en_q,
  output logic              en_fall,
  output logic              en_rise
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      en_q  <= 1'b0;
    end else if (reg_wr) begin
      ovr_q <= reg_wdata[OVR_BIT];
      en_q  <= reg_wdata[EN_BIT];
    end
  end

  // Named events for the message sequencer.
  assign en_fall = reg_wr & en_q & ~reg_wdata[EN_BIT];
  assign en_rise = reg_wr & ~en_q & reg_wdata[EN_BIT];

  always_comb begin
    reg_rdata          = '0;
    reg_rdata[OVR_BIT] = ovr_q;
    reg_rdata[EN_BIT]  = en_q;
  end

  a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata[OVR_BIT] == $past(reg_wdata[OVR_BIT])) &&
               (reg_rdata[EN_BIT]  == $past(reg_wdata[EN_BIT])));

endmodule

// File: rtl/rp_err_gate.sv
module rp_err_gate
  import rp_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ovr_q,
  input  logic rootctrl_ce_en,
  input  logic corr_err,
  output logic esc_pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) esc_pulse <= 1'b0;
    else        esc_pulse <= corr_err & esc_allowed(ovr_q, rootctrl_ce_en);
  end

  // R4: a pulse needs an error one cycle earlier under an open gate.
  a_r4_esc_cause: assert property (@(posedge clk) disable iff (!rst_n)
    esc_pulse |-> $past(corr_err) && ($past(ovr_q) || $past(rootctrl_ce_en)));

  // R3: override forwards every error.
  a_r3_override: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_err && ovr_q) |=> esc_pulse);

endmodule

// File: rtl/rp_pme_seq.sv
module rp_pme_seq
  import rp_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en_q,
  input  logic     en_fall,
  input  logic     en_rise,
  input  logic     acpi_mode,
  input  logic     pme_req,
  input  logic     pme_clr,
  input  logic     msg_ready,
  output logic     msg_valid,
  output pme_msg_e msg_type
);

  logic     pending_q;
  pme_msg_e type_q;
  logic     asserted_q;   // last accepted message was an assert
  logic     owed_q;       // enable was dropped; cleanup may be due

  logic gen_ok, accept;
  logic sched_cleanup, sched_assert, sched_deassert;

  assign gen_ok         = en_q & acpi_mode;
  assign accept         = pending_q & msg_ready;
  assign sched_cleanup  = ~pending_q & owed_q & asserted_q;
  assign sched_assert   = ~pending_q & ~sched_cleanup & gen_ok & pme_req & ~asserted_q;
  assign sched_deassert = ~pending_q & ~sched_cleanup & gen_ok & pme_clr & asserted_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q  <= 1'b0;
      type_q     <= MSG_ASSERT;
      asserted_q <= 1'b0;
      owed_q     <= 1'b0;
    end else begin
      if (accept) begin
        pending_q  <= 1'b0;
        asserted_q <= (type_q == MSG_ASSERT);
      end
      if (sched_cleanup || sched_deassert) begin
        pending_q <= 1'b1;
        type_q    <= MSG_DEASSERT;
      end else if (sched_assert) begin
        pending_q <= 1'b1;
        type_q    <= MSG_ASSERT;
      end
      if (en_fall)                        owed_q <= 1'b1;
      else if (en_rise || sched_cleanup)  owed_q <= 1'b0;
      else if (!pending_q && !asserted_q) owed_q <= 1'b0;
    end
  end

  assign msg_valid = pending_q;
  assign msg_type  = type_q;

  // R7: offered message is held unchanged until taken.
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid && $stable(msg_type));

  // R6: no assert is offered while the last accepted one was an assert.
  a_r6_no_double_assert: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == MSG_ASSERT) |-> !asserted_q);

  // R5: a fresh assert offer needs enable and ACPI mode one cycle earlier.
  a_r5_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(msg_valid) && msg_type == MSG_ASSERT) |-> $past(en_q) && $past(acpi_mode));

  // R8: an owed cleanup is offered on the next cycle.
  a_r8_cleanup: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_q && asserted_q && !pending_q) |=> msg_valid && msg_type == MSG_DEASSERT);

endmodule

// File: rtl/rp_pme_err_ctl.sv
module rp_pme_err_ctl
  import rp_ctl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int OVR_BIT = 1,
  parameter int EN_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rootctrl_ce_en,
  input  logic              acpi_mode,
  input  logic              corr_err,
  input  logic              pme_req,
  input  logic              pme_clr,
  output logic              esc_pulse,
  output logic              msg_valid,
  output logic              msg_type,
  input  logic              msg_ready
);

  logic     ovr_q, en_q, en_fall, en_rise;
  pme_msg_e msg_type_e;

  rp_ctl_regfile #(.DATA_W(DATA_W), .OVR_BIT(OVR_BIT), .EN_BIT(EN_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ovr_q(ovr_q), .en_q(en_q),
    .en_fall(en_fall), .en_rise(en_rise));

  rp_err_gate u_err (
    .clk(clk), .rst_n(rst_n), .ovr_q(ovr_q), .rootctrl_ce_en(rootctrl_ce_en),
    .corr_err(corr_err), .esc_pulse(esc_pulse));

  rp_pme_seq u_pme (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .en_fall(en_fall), .en_rise(en_rise),
    .acpi_mode(acpi_mode), .pme_req(pme_req), .pme_clr(pme_clr),
    .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_type(msg_type_e));

  assign msg_type = msg_type_e;

  // R1: nothing offered in the first cycle out of reset.
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !msg_valid && !esc_pulse);

endmodule

// File: tb/rp_pme_err_ctl_tb.sv
module rp_pme_err_ctl_tb;

  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic rootctrl_ce_en = 1'b0, acpi_mode = 1'b0, corr_err = 1'b0;
  logic pme_req = 1'b0, pme_clr = 1'b0, msg_ready = 1'b1;
  logic esc_pulse, msg_valid, msg_type;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  rp_pme_err_ctl #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rootctrl_ce_en(rootctrl_ce_en), .acpi_mode(acpi_mode),
    .corr_err(corr_err), .pme_req(pme_req), .pme_clr(pme_clr),
    .esc_pulse(esc_pulse), .msg_valid(msg_valid), .msg_type(msg_type),
    .msg_ready(msg_ready));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: every accepted message is compared with the scoreboard.
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6/R9 unexpected message", msg_type, 2);
      end else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(msg_type == e, t, msg_type, e);
      end
    end
  end

  task automatic expect_msg(input logic typ, input string tag);
    exp_q.push_back(typ);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic corr(input logic exp_esc, input string tag);
    @(negedge clk);
    corr_err = 1'b1;
    @(negedge clk);
    corr_err = 1'b0;
    check(esc_pulse == exp_esc, tag, esc_pulse, exp_esc);
    @(negedge clk);
    check(esc_pulse == 1'b0, "R4 pulse width", esc_pulse, 0);
  endtask

  task automatic pulse_req();
    @(negedge clk); pme_req = 1'b1;
    @(negedge clk); pme_req = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); pme_clr = 1'b1;
    @(negedge clk); pme_clr = 1'b0;
  endtask

  task automatic drained(input string tag);
    idle(4);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    check(msg_valid == 1'b0, tag, msg_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(reg_rdata == '0, "R1 reset read", reg_rdata, 0);
    check(msg_valid == 1'b0, "R1 reset valid", msg_valid, 0);
    check(esc_pulse == 1'b0, "R1 reset esc", esc_pulse, 0);

    // R2: only bits 1:0 stick
    wr('1);
    check(reg_rdata == 32'h3, "R2 read all-ones write", reg_rdata, 3);
    wr(32'h2);
    check(reg_rdata == 32'h2, "R2 read override only", reg_rdata, 2);
    wr(32'h0);
    check(reg_rdata == 32'h0, "R2 read cleared", reg_rdata, 0);

    // R4: override off
    rootctrl_ce_en = 1'b0; corr(1'b0, "R4 gated off");
    rootctrl_ce_en = 1'b1; corr(1'b1, "R4 root-control on");
    // R3: override on
    wr(32'h2);
    rootctrl_ce_en = 1'b0; corr(1'b1, "R3 override, root-control off");
    rootctrl_ce_en = 1'b1; corr(1'b1, "R3 override, root-control on");
    wr(32'h0);

    // R5: gating
    acpi_mode = 1'b1;
    pulse_req();
    drained("R5 enable off");
    wr(32'h1); acpi_mode = 1'b0;
    pulse_req();
    drained("R5 acpi off");

    // R6: assert/deassert alternation
    acpi_mode = 1'b1;
    expect_msg(1'b0, "R6 first assert");
    pulse_req(); drained("R6 assert sent");
    pulse_req(); drained("R6 repeated request ignored");
    expect_msg(1'b1, "R6 deassert");
    pulse_clr(); drained("R6 deassert sent");
    pulse_clr(); drained("R6 repeated clear ignored");

    // R7: backpressure
    msg_ready = 1'b0;
    expect_msg(1'b0, "R7 held assert");
    pulse_req();
    for (int i = 0; i < 4; i++) begin
      check(msg_valid == 1'b1 && msg_type == 1'b0, "R7 held while not ready",
            {msg_valid, msg_type}, 2'b10);
      if (i == 1) begin pme_clr = 1'b1; @(negedge clk); pme_clr = 1'b0; end
      else @(negedge clk);
    end
    msg_ready = 1'b1;
    drained("R7 accepted, clear during wait ignored");

    // R8: disable with assert outstanding
    expect_msg(1'b1, "R8 cleanup deassert");
    wr(32'h0);
    drained("R8 exactly one cleanup");
    // R8 with ACPI mode off
    wr(32'h1);
    expect_msg(1'b0, "R8 assert before acpi drop");
    pulse_req(); drained("R8 assert sent");
    acpi_mode = 1'b0;
    expect_msg(1'b1, "R8 cleanup with acpi off");
    wr(32'h0);
    drained("R8 cleanup acpi off done");
    acpi_mode = 1'b1;

    // R9: no cleanup after deassert or nothing
    wr(32'h1); wr(32'h0);
    drained("R9 nothing sent");
    wr(32'h1);
    expect_msg(1'b0, "R9 assert");
    pulse_req(); drained("R9 assert done");
    expect_msg(1'b1, "R9 deassert");
    pulse_clr(); drained("R9 deassert done");
    wr(32'h0);
    drained("R9 disable after deassert");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule